// File: doc/BRIEF.md
# Flash Program/Erase Status Reporter

This block is the status side of a parallel NOR flash model. It holds a small word array split into equal sectors, each with a protect bit from an input mask. The host writes command sequences on a single-cycle write strobe. Once a program or erase has been accepted, reads stop returning array contents and return a status word instead. Bit 7 of that word is the polling bit. Bit 6 is the toggle bit. Bits 5..0 read as zero.

A host polls the status word until the toggle bit stops changing or the polling bit matches the data it expects. Then it reads real data again. Programming a protected word, or erasing a set of sectors that are all protected, still yields a timed busy window that shows the same status pattern, but the array is left untouched. Every duration is a parameter counted in clock cycles.

Two FSMs drive the block. The command FSM has the states CS_IDLE, CS_U1, CS_U2, CS_PROG_ARM, CS_ERASE_ARM, CS_E_U1 and CS_E_U2:
- Each matching write advances it by one state.
- Any write that does not match returns it to CS_IDLE.
- It is held in CS_IDLE while an operation is running.

The operation FSM has the states OP_READ, OP_PROG, OP_PROG_PROT, OP_ERASE_TO, OP_ERASE and OP_ERASE_PROT, with these transitions:
- OP_READ moves to OP_PROG, or to OP_PROG_PROT if the target sector is protected, on the final program write.
- OP_READ moves to OP_ERASE, or to OP_ERASE_PROT if every sector is protected, on the chip-erase write.
- OP_READ moves to OP_ERASE_TO on the sector-erase write.
- OP_ERASE_TO reloads its window on each further sector write.
- When the window expires, OP_ERASE_TO moves to OP_ERASE if any selected sector is unprotected, and to OP_ERASE_PROT otherwise.
- Every busy state returns to OP_READ when its counter runs out.

Top module: `flash_status_top`

## Requirements
- R1: A program is the write sequence (addr 5, 0xAA), (addr 2, 0x55), (addr 5, 0xA0), (PA, PD). The block is busy from the clock edge of the fourth write for PROG_CYC cycles. After that, word PA holds its old value AND PD.
- R2: During a program (protected or not), a read returns bit 7 equal to the inverse of PD bit 7. After completion, reads return the true stored word.
- R3: A chip erase is (5,0xAA), (2,0x55), (5,0x80), (5,0xAA), (2,0x55), (5,0x10). It is busy for ERASE_CYC cycles and reads return bit 7 = 0 meanwhile. Afterwards, erased words read 0xFF, so bit 7 reads 1.
- R4: Each read taken while busy returns bit 6 inverted from the previous busy read. Bit 6 is 0 on the first busy read after reset. Status bits 5..0 read 0.
- R5: A sector erase ends with (SA, 0x30) in place of (5,0x10). This opens a window of ERASE_WIN_CYC cycles in which reads show erase status. A further write of 0x30 to any address adds that address's sector and restarts the window. When the window ends, the erase runs for ERASE_CYC cycles.
- R6: Programming a word in a protected sector gives a PROT_PROG_CYC-cycle busy window and leaves the array unchanged.
- R7: An erase sets every word of the selected unprotected sectors to all ones and leaves the protected sectors unchanged. The sector is address bits [ADDR_W-1:ADDR_W-2] for the default four sectors.
- R8: If every selected sector is protected, the block stays busy for PROT_ERASE_CYC cycles and then returns to reads with no data altered.
- R9: Writes that break a sequence return the decoder to idle with no effect. Writes during a program or erase are ignored, except the sector-add write in R5.
- R10: After reset, every word reads 0xFF and no operation is running.
- R11: rd_data is updated on the clock edge where rd_en is high and holds its value when rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle command write strobe |
| wr_addr | input | ADDR_W | Command/word address |
| wr_data | input | DATA_W | Command code or program data |
| rd_en | input | 1 | Read access strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Array word or status word |
| prot_mask | input | SECTORS | Per-sector protect bits |

## Verification
Let the last write of a sequence land on clock edge E. Reads at edges E+1 through E+N return status, where N is the window length of the running state. The first read that returns data is at edge E+N+1. Each read result appears on rd_data one edge after rd_en. The bench drives every input at the falling edge and compares at the next falling edge. A bench model steps once per clock, reading its state before each edge and advancing it after. Every compare therefore falls in exactly the cycle in which the design produces its result, including the last busy read and the first data read.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_U1,
        CS_U2,
        CS_PROG_ARM,
        CS_ERASE_ARM,
        CS_E_U1,
        CS_E_U2
    } cmd_state_t;

    typedef enum logic [2:0] {
        OP_READ,
        OP_PROG,
        OP_PROG_PROT,
        OP_ERASE_TO,
        OP_ERASE,
        OP_ERASE_PROT
    } op_state_t;

    localparam logic [7:0] CODE_UNLOCK1 = 8'hAA;
    localparam logic [7:0] CODE_UNLOCK2 = 8'h55;
    localparam logic [7:0] CODE_PROG    = 8'hA0;
    localparam logic [7:0] CODE_ESETUP  = 8'h80;
    localparam logic [7:0] CODE_CHIP    = 8'h10;
    localparam logic [7:0] CODE_SECT    = 8'h30;

    localparam int POLL_BIT = 7;
    localparam int TOG_BIT  = 6;

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_status_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int UNLOCK_A = 5,
    parameter int UNLOCK_B = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ev_prog,
    output logic              ev_chip,
    output logic              ev_sect
);

    localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(UNLOCK_A);
    localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(UNLOCK_B);

    cmd_state_t cs, cs_n;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                                 input logic [ADDR_W-1:0] wa, input logic [7:0] c);
        return (a == wa) && (d == c);
    endfunction

    logic [7:0] code;
    assign code = wr_data[7:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs <= CS_IDLE;
        else        cs <= cs_n;
    end

    always_comb begin
        cs_n    = cs;
        ev_prog = 1'b0;
        ev_chip = 1'b0;
        ev_sect = 1'b0;
        if (!enable) begin
            cs_n = CS_IDLE;
        end else if (wr_en) begin
            cs_n = CS_IDLE;
            unique case (cs)
                CS_IDLE:      if (hit(wr_addr, code, ADR_A, CODE_UNLOCK1)) cs_n = CS_U1;
                CS_U1:        if (hit(wr_addr, code, ADR_B, CODE_UNLOCK2)) cs_n = CS_U2;
                CS_U2: begin
                    if (hit(wr_addr, code, ADR_A, CODE_PROG))        cs_n = CS_PROG_ARM;
                    else if (hit(wr_addr, code, ADR_A, CODE_ESETUP)) cs_n = CS_ERASE_ARM;
                end
                CS_PROG_ARM:  ev_prog = 1'b1;
                CS_ERASE_ARM: if (hit(wr_addr, code, ADR_A, CODE_UNLOCK1)) cs_n = CS_E_U1;
                CS_E_U1:      if (hit(wr_addr, code, ADR_B, CODE_UNLOCK2)) cs_n = CS_E_U2;
                CS_E_U2: begin
                    if (hit(wr_addr, code, ADR_A, CODE_CHIP)) ev_chip = 1'b1;
                    else if (code == CODE_SECT)               ev_sect = 1'b1;
                end
                default:      cs_n = CS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl
    import flash_status_pkg::*;
#(
    parameter int ADDR_W         = 3,
    parameter int DATA_W         = 8,
    parameter int SECTORS        = 4,
    parameter int PROG_CYC       = 16,
    parameter int ERASE_CYC      = 48,
    parameter int PROT_PROG_CYC  = 8,
    parameter int PROT_ERASE_CYC = 32,
    parameter int ERASE_WIN_CYC  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_prog,
    input  logic               ev_chip,
    input  logic               ev_sect,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [SECTORS-1:0] prot_mask,
    output op_state_t          op_st,
    output logic               busy,
    output logic               prog_b7,
    output logic               do_prog,
    output logic [ADDR_W-1:0]  prog_addr,
    output logic [DATA_W-1:0]  prog_data,
    output logic               do_erase,
    output logic [SECTORS-1:0] erase_mask
);

    localparam int SECT_W = $clog2(SECTORS);
    localparam int MAX_A  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int MAX_B  = (PROT_PROG_CYC > PROT_ERASE_CYC) ? PROT_PROG_CYC : PROT_ERASE_CYC;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CYC = (MAX_C > ERASE_WIN_CYC) ? MAX_C : ERASE_WIN_CYC;
    localparam int CNT_W  = $clog2(MAX_CYC + 1);

    op_state_t          st, st_n;
    logic [CNT_W-1:0]   cnt, cnt_n;
    logic [SECTORS-1:0] sel, sel_n;
    logic [ADDR_W-1:0]  pa, pa_n;
    logic [DATA_W-1:0]  pd, pd_n;

    function automatic logic [SECT_W-1:0] sect_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: SECT_W];
    endfunction

    function automatic logic [CNT_W-1:0] load(input int n);
        return CNT_W'(n - 1);
    endfunction

    logic [SECTORS-1:0] wr_sect_bit;
    logic               ext_hit;
    logic               live_sel;

    assign wr_sect_bit = SECTORS'(1) << sect_of(wr_addr);
    assign ext_hit     = wr_en && (wr_data[7:0] == CODE_SECT);
    assign live_sel    = |(sel & ~prot_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= OP_READ;
            cnt <= '0;
            sel <= '0;
            pa  <= '0;
            pd  <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            sel <= sel_n;
            pa  <= pa_n;
            pd  <= pd_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        sel_n = sel;
        pa_n  = pa;
        pd_n  = pd;
        unique case (st)
            OP_READ: begin
                if (ev_prog) begin
                    pa_n = wr_addr;
                    pd_n = wr_data;
                    if (prot_mask[sect_of(wr_addr)]) begin
                        st_n  = OP_PROG_PROT;
                        cnt_n = load(PROT_PROG_CYC);
                    end else begin
                        st_n  = OP_PROG;
                        cnt_n = load(PROG_CYC);
                    end
                end else if (ev_chip) begin
                    sel_n = '1;
                    if (&prot_mask) begin
                        st_n  = OP_ERASE_PROT;
                        cnt_n = load(PROT_ERASE_CYC);
                    end else begin
                        st_n  = OP_ERASE;
                        cnt_n = load(ERASE_CYC);
                    end
                end else if (ev_sect) begin
                    sel_n = wr_sect_bit;
                    st_n  = OP_ERASE_TO;
                    cnt_n = load(ERASE_WIN_CYC);
                end
            end
            OP_ERASE_TO: begin
                if (ext_hit) begin
                    sel_n = sel | wr_sect_bit;
                    cnt_n = load(ERASE_WIN_CYC);
                end else if (cnt == '0) begin
                    if (live_sel) begin
                        st_n  = OP_ERASE;
                        cnt_n = load(ERASE_CYC);
                    end else begin
                        st_n  = OP_ERASE_PROT;
                        cnt_n = load(PROT_ERASE_CYC);
                    end
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            OP_PROG, OP_PROG_PROT, OP_ERASE, OP_ERASE_PROT: begin
                if (cnt == '0) st_n = OP_READ;
                else           cnt_n = cnt - 1'b1;
            end
            default: st_n = OP_READ;
        endcase
    end

    always_comb begin
        op_st      = st;
        busy       = (st != OP_READ);
        prog_b7    = pd[7];
        prog_addr  = pa;
        prog_data  = pd;
        do_prog    = (st == OP_PROG) && (cnt == '0);
        do_erase   = (st == OP_ERASE) && (cnt == '0);
        erase_mask = sel & ~prot_mask;
    end

endmodule

// File: rtl/flash_word_store.sv
module flash_word_store #(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 8,
    parameter int SECTORS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               do_prog,
    input  logic [ADDR_W-1:0]  prog_addr,
    input  logic [DATA_W-1:0]  prog_data,
    input  logic               do_erase,
    input  logic [SECTORS-1:0] erase_mask,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_word
);

    localparam int WORDS  = 1 << ADDR_W;
    localparam int SECT_W = $clog2(SECTORS);

    logic [DATA_W-1:0] mem [WORDS];

    function automatic logic [SECT_W-1:0] sect_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: SECT_W];
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else if (do_prog) begin
            mem[prog_addr] <= mem[prog_addr] & prog_data;
        end else if (do_erase) begin
            for (int i = 0; i < WORDS; i++)
                if (erase_mask[sect_of(ADDR_W'(i))]) mem[i] <= '1;
        end
    end

    assign rd_word = mem[rd_addr];

endmodule

// File: rtl/flash_status_top.sv
module flash_status_top
    import flash_status_pkg::*;
#(
    parameter int ADDR_W         = 3,
    parameter int DATA_W         = 8,
    parameter int SECTORS        = 4,
    parameter int UNLOCK_A       = 5,
    parameter int UNLOCK_B       = 2,
    parameter int PROG_CYC       = 16,
    parameter int ERASE_CYC      = 48,
    parameter int PROT_PROG_CYC  = 8,
    parameter int PROT_ERASE_CYC = 32,
    parameter int ERASE_WIN_CYC  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [SECTORS-1:0] prot_mask
);

    logic               ev_prog, ev_chip, ev_sect;
    op_state_t          op_st;
    logic               busy, prog_b7;
    logic               do_prog, do_erase;
    logic [ADDR_W-1:0]  prog_addr;
    logic [DATA_W-1:0]  prog_data;
    logic [SECTORS-1:0] erase_mask;
    logic [DATA_W-1:0]  rd_word;
    logic [DATA_W-1:0]  status_word;
    logic               tog_q;

    flash_cmd_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(!busy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ev_prog(ev_prog), .ev_chip(ev_chip), .ev_sect(ev_sect)
    );

    flash_op_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECTORS(SECTORS),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
        .PROT_PROG_CYC(PROT_PROG_CYC), .PROT_ERASE_CYC(PROT_ERASE_CYC),
        .ERASE_WIN_CYC(ERASE_WIN_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ev_prog(ev_prog), .ev_chip(ev_chip), .ev_sect(ev_sect),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .prot_mask(prot_mask),
        .op_st(op_st), .busy(busy), .prog_b7(prog_b7),
        .do_prog(do_prog), .prog_addr(prog_addr), .prog_data(prog_data),
        .do_erase(do_erase), .erase_mask(erase_mask)
    );

    flash_word_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECTORS(SECTORS)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .do_prog(do_prog), .prog_addr(prog_addr), .prog_data(prog_data),
        .do_erase(do_erase), .erase_mask(erase_mask),
        .rd_addr(rd_addr), .rd_word(rd_word)
    );

    always_comb begin
        status_word = '0;
        status_word[POLL_BIT] = ((op_st == OP_PROG) || (op_st == OP_PROG_PROT)) ? ~prog_b7 : 1'b0;
        status_word[TOG_BIT]  = tog_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            tog_q   <= 1'b0;
        end else if (rd_en) begin
            rd_data <= busy ? status_word : rd_word;
            if (busy) tog_q <= ~tog_q;
        end
    end

endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk
    import flash_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input op_state_t         op_st,
    input logic              busy,
    input logic              prog_b7,
    input logic              do_prog,
    input logic              do_erase
);

    p_poll_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && ((op_st == OP_PROG) || (op_st == OP_PROG_PROT))
        |=> rd_data[POLL_BIT] == ~$past(prog_b7));

    p_poll_erase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && ((op_st == OP_ERASE) || (op_st == OP_ERASE_TO) || (op_st == OP_ERASE_PROT))
        |=> rd_data[POLL_BIT] == 1'b0);

    p_toggle_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && busy && $past(rd_en) && $past(busy)
        |=> rd_data[TOG_BIT] != $past(rd_data[TOG_BIT]));

    p_status_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && busy |=> rd_data[5:0] == 6'd0);

    p_prot_prog_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_st == OP_PROG_PROT) |-> !do_prog);

    p_prot_erase_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_st == OP_ERASE_PROT) |-> !do_erase);

    p_idle_no_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(do_prog || do_erase));

    p_read_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind flash_status_top flash_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data),
    .op_st(op_st), .busy(busy), .prog_b7(prog_b7),
    .do_prog(do_prog), .do_erase(do_erase)
);

// File: tb/sim_flash_status_top.sv
module sim_flash_status_top;

    localparam int CLK_PERIOD = 10;
    localparam int PC = 16, EC = 48, PP = 8, PE = 32, WC = 12;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, rd_en;
    logic [2:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic [3:0] prot_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_top #(
        .ADDR_W(3), .DATA_W(8), .SECTORS(4), .UNLOCK_A(5), .UNLOCK_B(2),
        .PROG_CYC(PC), .ERASE_CYC(EC), .PROT_PROG_CYC(PP),
        .PROT_ERASE_CYC(PE), .ERASE_WIN_CYC(WC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .prot_mask(prot_mask)
    );

    int n_cmp = 0, n_err = 0;
    bit finished = 0;

    // bench model: 0 read,1 prog,2 prog-prot,3 erase window,4 erase,5 erase-prot
    int         m_st = 0, m_rem = 0;
    logic [3:0] m_sel = 0;
    logic [2:0] m_pa = 0;
    logic [7:0] m_pd = 0;
    logic       m_tog = 0;
    logic [7:0] m_mem [8];

    function automatic string auto_tag(int s);
        case (s)
            0: return "R11 array read";
            1: return "R2 program status";
            2: return "R6 protected program status";
            3: return "R5 erase window status";
            4: return "R3 erase status";
            default: return "R8 protected erase status";
        endcase
    endfunction

    function automatic logic [7:0] model_read(input logic [2:0] ra);
        logic [7:0] r;
        if (m_st == 0) return m_mem[ra];
        r = 8'h00;
        r[7] = (m_st == 1 || m_st == 2) ? ~m_pd[7] : 1'b0;
        r[6] = m_tog;
        m_tog = ~m_tog;
        return r;
    endfunction

    function automatic void model_advance(input bit we, input logic [2:0] wa,
                                          input logic [7:0] wd, input int start);
        case (m_st)
            0: begin
                if (start == 1) begin
                    m_pa = wa; m_pd = wd;
                    if (prot_mask[wa[2:1]]) begin m_st = 2; m_rem = PP-1; end
                    else begin m_st = 1; m_rem = PC-1; end
                end else if (start == 2) begin
                    m_sel = 4'hF;
                    if (&prot_mask) begin m_st = 5; m_rem = PE-1; end
                    else begin m_st = 4; m_rem = EC-1; end
                end else if (start == 3) begin
                    m_sel = 4'b0001 << wa[2:1]; m_st = 3; m_rem = WC-1;
                end
            end
            3: begin
                if (we && wd == 8'h30) begin
                    m_sel = m_sel | (4'b0001 << wa[2:1]); m_rem = WC-1;
                end else if (m_rem == 0) begin
                    if ((m_sel & ~prot_mask) != 0) begin m_st = 4; m_rem = EC-1; end
                    else begin m_st = 5; m_rem = PE-1; end
                end else m_rem--;
            end
            default: begin
                if (m_rem == 0) begin
                    if (m_st == 1) m_mem[m_pa] = m_mem[m_pa] & m_pd;
                    if (m_st == 4)
                        for (int i = 0; i < 8; i++)
                            if ((m_sel & ~prot_mask) & (4'b0001 << (i >> 1))) m_mem[i] = 8'hFF;
                    m_st = 0;
                end else m_rem--;
            end
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: drive at falling edge, compare at the next falling edge
    task automatic cyc(input bit we, input logic [2:0] wa, input logic [7:0] wd,
                       input bit re, input logic [2:0] ra, input int start, input string tag);
        logic [7:0] e;
        string t;
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        t = (tag == "") ? auto_tag(m_st) : tag;
        e = 8'h00;
        if (re) e = model_read(ra);
        @(posedge clk);
        model_advance(we, wa, wd, start);
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        if (re) chk(t, rd_data, e);
    endtask

    task automatic wc(input logic [2:0] a, input logic [7:0] d, input int start, input bit rr);
        cyc(1'b1, a, d, rr ? 1'($urandom_range(0,1)) : 1'b0, 3'($urandom_range(0,7)), start, "");
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        cyc(1'b0, 3'd0, 8'h00, 1'b1, a, 0, tag);
    endtask

    task automatic idle(input bit rr);
        cyc(1'b0, 3'd0, 8'h00, rr ? 1'($urandom_range(0,1)) : 1'b0, 3'($urandom_range(0,7)), 0, "");
    endtask

    task automatic seq_prog(input logic [2:0] a, input logic [7:0] d, input bit rr);
        wc(3'd5, 8'hAA, 0, rr); wc(3'd2, 8'h55, 0, rr); wc(3'd5, 8'hA0, 0, rr); wc(a, d, 1, rr);
    endtask

    task automatic seq_erase(input bit chip, input logic [2:0] a, input bit rr);
        wc(3'd5, 8'hAA, 0, rr); wc(3'd2, 8'h55, 0, rr); wc(3'd5, 8'h80, 0, rr);
        wc(3'd5, 8'hAA, 0, rr); wc(3'd2, 8'h55, 0, rr);
        if (chip) wc(3'd5, 8'h10, 2, rr);
        else      wc(a, 8'h30, 3, rr);
    endtask

    task automatic settle_reading(input logic [2:0] a);
        while (m_st != 0) rd(a, "");
    endtask

    task automatic settle(input bit rr);
        while (m_st != 0) idle(rr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) m_mem[i] = 8'hFF;
        rst_n = 0; wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0; prot_mask = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R10 reset contents
        for (int i = 0; i < 8; i++) rd(3'(i), "R10 reset word");

        // R1 program and timing of busy window
        seq_prog(3'd3, 8'h5A, 1'b0);
        rd(3'd3, "R1 busy from fourth write");
        for (int k = 2; k <= PC; k++) rd(3'd3, "R4 toggle while programming");
        rd(3'd3, "R1 programmed word after window");
        seq_prog(3'd3, 8'hF0, 1'b0);
        settle(1'b0);
        rd(3'd3, "R1 old AND new");

        // R11 output holds without read strobe
        held = rd_data;
        idle(1'b0); chk("R11 hold after idle", rd_data, held);
        idle(1'b0); chk("R11 hold after second idle", rd_data, held);

        // preload data in every sector
        seq_prog(3'd0, 8'h12, 1'b0); settle(1'b0);
        seq_prog(3'd2, 8'h34, 1'b0); settle(1'b0);
        seq_prog(3'd4, 8'h56, 1'b0); settle(1'b0);
        seq_prog(3'd6, 8'h78, 1'b0); settle(1'b0);

        // R9 broken sequences and writes during busy
        wc(3'd5, 8'hAA, 0, 0); wc(3'd3, 8'h55, 0, 0); wc(3'd5, 8'hA0, 0, 0); wc(3'd7, 8'h00, 0, 0);
        rd(3'd7, "R9 wrong unlock address ignored");
        wc(3'd5, 8'hAA, 0, 0); wc(3'd2, 8'h55, 0, 0); wc(3'd5, 8'h77, 0, 0); wc(3'd7, 8'h00, 0, 0);
        rd(3'd7, "R9 unknown code ignored");
        wc(3'd5, 8'hAA, 0, 0); wc(3'd2, 8'h55, 0, 0); wc(3'd5, 8'h80, 0, 0);
        wc(3'd5, 8'hAA, 0, 0); wc(3'd2, 8'h55, 0, 0); wc(3'd5, 8'h20, 0, 0);
        rd(3'd0, "R9 bad erase code ignored");
        seq_prog(3'd5, 8'h0F, 1'b0);
        wc(3'd5, 8'hAA, 0, 0); wc(3'd2, 8'h55, 0, 0); wc(3'd5, 8'hA0, 0, 0); wc(3'd7, 8'h00, 0, 0);
        settle_reading(3'd7);
        rd(3'd7, "R9 writes while busy ignored");
        rd(3'd5, "R1 program with writes during busy");

        // R7 chip erase with sector 1 protected
        prot_mask = 4'b0010;
        seq_erase(1'b1, 3'd0, 1'b0);
        settle_reading(3'd1);
        for (int i = 0; i < 8; i++) rd(3'(i), "R7 chip erase skips protected");

        // R5 sector erase with a sector added in the window
        prot_mask = 4'b0000;
        seq_prog(3'd0, 8'h21, 1'b0); settle(1'b0);
        seq_prog(3'd4, 8'h43, 1'b0); settle(1'b0);
        seq_prog(3'd7, 8'h65, 1'b0); settle(1'b0);
        seq_erase(1'b0, 3'd4, 1'b0);
        rd(3'd4, "R5 window status");
        rd(3'd4, "R5 window status toggled");
        wc(3'd7, 8'h30, 0, 0);
        settle_reading(3'd0);
        for (int i = 0; i < 8; i++) rd(3'(i), "R5 selected sectors erased");

        // R6 protected program
        prot_mask = 4'b0001;
        seq_prog(3'd0, 8'h00, 1'b0);
        settle_reading(3'd0);
        rd(3'd0, "R6 protected word unchanged");

        // R8 all selected sectors protected
        seq_erase(1'b0, 3'd1, 1'b0);
        settle_reading(3'd1);
        rd(3'd0, "R8 protected erase no change");
        prot_mask = 4'hF;
        seq_erase(1'b1, 3'd0, 1'b0);
        settle_reading(3'd2);
        for (int i = 0; i < 8; i++) rd(3'(i), "R8 fully protected chip erase");

        // constrained random mix
        for (int it = 0; it < 30; it++) begin
            int op;
            prot_mask = ($urandom_range(0,3) == 0) ? 4'($urandom) : 4'b0000;
            op = $urandom_range(0,5);
            case (op)
                0, 1: seq_prog(3'($urandom), 8'($urandom), 1'b1);
                2: begin
                    seq_erase(1'b0, 3'($urandom), 1'b1);
                    idle(1'b1);
                    wc(3'($urandom), 8'h30, 0, 1'b1);
                end
                3: seq_erase(1'b1, 3'd0, 1'b1);
                default: repeat (4) idle(1'b1);
            endcase
            settle(1'b1);
            for (int i = 0; i < 8; i++) rd(3'(i), "R11 random read back");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

endmodule